// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block takes a trap (a synchronous exception or an interrupt) and performs every register update that trap entry needs, in one clock edge. It receives the trap code, a flag that marks an interrupt, the faulting address and the trapping PC. It also receives the hart's current privilege and status-stack fields, the two delegation masks and the two trap-vector bases.

From these it chooses the handling level: supervisor or machine. It pushes the interrupt-enable and privilege stack for that level and fills that level's cause, exception-PC and trap-value registers. It switches privilege and produces the address of the first handler instruction.

A pipeline raises `trap_valid` for one cycle per trap. The registered results appear after that clock edge and are held until the next trap. Outside a trap, the status outputs hold their last values. The surrounding control-register file feeds these values back as the "current" inputs.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset the outputs are: privilege 3 (machine), all enable and stack bits 0, previous-privilege fields 0, and cause, exception-PC, trap-value and next-PC all zero.
- R2: Privilege encodings are user=0, supervisor=1 and machine=3. A trap goes to supervisor (`priv_o`=1) only when `cur_priv` is 0 or 1 and bit `code` of the mask is set; otherwise it goes to machine (`priv_o`=3). The mask is `irq_deleg` for interrupts and `exc_deleg` for exceptions.
- R3: On supervisor entry the outputs become: `spie_o` = `cur_sie`, `spp_o` = `cur_priv[0]`, `sie_o` = 0. `mie_o`, `mpie_o` and `mpp_o` copy `cur_mie`, `cur_mpie` and `cur_mpp`.
- R4: On machine entry the outputs become: `mpie_o` = `cur_mie`, `mpp_o` = `cur_priv`, `mie_o` = 0. `sie_o`, `spie_o` and `spp_o` copy `cur_sie`, `cur_spie` and `cur_spp`.
- R5: The target level's cause register receives the effective code, zero-extended, with bit XLEN-1 set for interrupts. The other level's cause, exception-PC and trap-value registers are unchanged.
- R6: The target level's exception-PC register receives `trap_pc`.
- R7: `npc_o` is the target level's vector base with bits [1:0] cleared. When the trap is an interrupt and the base's bits [1:0] equal 1, 4 times the code is added. Modes 0, 2 and 3 use the base alone.
- R8: The target level's trap-value register receives `trap_addr` only for the exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It receives zero for every other exception code and for all interrupts.
- R9: An exception with code 8, 9 or 11 is an environment call. Its code is replaced by 8, 9 or 11 for `cur_priv` user, supervisor or machine. The replaced code is the one used for delegation and written to the cause register.
- R10: When `trap_valid` is low, every output holds its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_is_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Exception or interrupt code |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege |
| cur_sie | input | 1 | Current supervisor interrupt enable |
| cur_spie | input | 1 | Current supervisor previous enable |
| cur_spp | input | 1 | Current supervisor previous privilege |
| cur_mie | input | 1 | Current machine interrupt enable |
| cur_mpie | input | 1 | Current machine previous enable |
| cur_mpp | input | 2 | Current machine previous privilege |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| m_tvec | input | XLEN | Machine vector base and mode |
| s_tvec | input | XLEN | Supervisor vector base and mode |
| priv_o | output | 2 | New privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| npc_o | output | XLEN | Handler entry address |

## Verification
The environment-call rewrite and the delegation decision happen in the same cycle, and the rewritten code must steer the delegation lookup. The bench provokes the conflict by raising code 9 from user level with only mask bit 8 set. The trap must land in supervisor with cause 8, and a mismatch shows up both in `priv_o` and in the cause written.

A full sweep crosses every code 0..15 with both trap kinds, three privileges, three mask patterns and three vector modes. Every output is compared with an arithmetic model. An idle cycle with scrambled inputs follows each trap to confirm the hold behaviour.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] PRIV_USER  = 2'd0;
  localparam logic [1:0] PRIV_SUPER = 2'd1;
  localparam logic [1:0] PRIV_MACH  = 2'd3;

  localparam int CODE_FETCH_MIS = 0;
  localparam int CODE_FETCH_ACC = 1;
  localparam int CODE_LOAD_MIS  = 4;
  localparam int CODE_LOAD_ACC  = 5;
  localparam int CODE_STORE_MIS = 6;
  localparam int CODE_STORE_ACC = 7;
  localparam int CODE_CALL_U    = 8;
  localparam int CODE_CALL_S    = 9;
  localparam int CODE_CALL_M    = 11;
  localparam int CODE_FETCH_PF  = 12;
  localparam int CODE_LOAD_PF   = 13;
  localparam int CODE_STORE_PF  = 15;

  localparam logic [1:0] VEC_MODE_TABLE = 2'd1;
endpackage

// File: rtl/trap_code_fix.sv
module trap_code_fix #(
  parameter int CODE_W = 5
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code_in,
  input  logic [1:0]        priv,
  output logic [CODE_W-1:0] code_eff,
  output logic              addr_bearing
);
  import trap_pkg::*;

  // environment-call renaming (R9)
  always_comb begin
    code_eff = code_in;
    if (!is_irq) begin
      case (code_in)
        CODE_W'(CODE_CALL_U), CODE_W'(CODE_CALL_S), CODE_W'(CODE_CALL_M): begin
          case (priv)
            PRIV_USER:  code_eff = CODE_W'(CODE_CALL_U);
            PRIV_SUPER: code_eff = CODE_W'(CODE_CALL_S);
            default:    code_eff = CODE_W'(CODE_CALL_M);
          endcase
        end
        default: code_eff = code_in;
      endcase
    end
  end

  // codes that carry a faulting address (R8)
  always_comb begin
    addr_bearing = 1'b0;
    if (!is_irq) begin
      case (code_eff)
        CODE_W'(CODE_FETCH_MIS), CODE_W'(CODE_FETCH_ACC),
        CODE_W'(CODE_LOAD_MIS),  CODE_W'(CODE_LOAD_ACC),
        CODE_W'(CODE_STORE_MIS), CODE_W'(CODE_STORE_ACC),
        CODE_W'(CODE_FETCH_PF),  CODE_W'(CODE_LOAD_PF),
        CODE_W'(CODE_STORE_PF): addr_bearing = 1'b1;
        default:                addr_bearing = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        priv,
  input  logic [XLEN-1:0]   exc_mask,
  input  logic [XLEN-1:0]   irq_mask,
  output logic              to_super
);
  import trap_pkg::*;

  logic [XLEN-1:0] mask_sel;
  logic [XLEN-1:0] mask_shift;
  logic            low_priv;

  always_comb begin
    mask_sel   = is_irq ? irq_mask : exc_mask;
    // a shift past the mask width yields zero: codes >= XLEN never delegate
    mask_shift = mask_sel >> code;
    low_priv   = (priv == PRIV_USER) || (priv == PRIV_SUPER);
    to_super   = low_priv && mask_shift[0];
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [XLEN-1:0]   tvec,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   npc
);
  import trap_pkg::*;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic            use_table;

  always_comb begin
    base      = {tvec[XLEN-1:2], 2'b00};
    use_table = is_irq && (tvec[1:0] == VEC_MODE_TABLE);
    offset    = use_table ? (XLEN'(code) << 2) : '0;
    npc       = base + offset;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  input  logic              trap_is_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_addr,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic [1:0]        cur_priv,
  input  logic              cur_sie,
  input  logic              cur_spie,
  input  logic              cur_spp,
  input  logic              cur_mie,
  input  logic              cur_mpie,
  input  logic [1:0]        cur_mpp,
  input  logic [XLEN-1:0]   exc_deleg,
  input  logic [XLEN-1:0]   irq_deleg,
  input  logic [XLEN-1:0]   m_tvec,
  input  logic [XLEN-1:0]   s_tvec,
  output logic [1:0]        priv_o,
  output logic              sie_o,
  output logic              spie_o,
  output logic              spp_o,
  output logic              mie_o,
  output logic              mpie_o,
  output logic [1:0]        mpp_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mtval_o,
  output logic [XLEN-1:0]   scause_o,
  output logic [XLEN-1:0]   sepc_o,
  output logic [XLEN-1:0]   stval_o,
  output logic [XLEN-1:0]   npc_o
);
  import trap_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [CODE_W-1:0] code_eff;
  logic              addr_bearing;
  logic              to_super;
  logic [XLEN-1:0]   tvec_sel;
  logic [XLEN-1:0]   npc_calc;

  trap_code_fix #(.CODE_W(CODE_W)) u_fix (
    .is_irq       (trap_is_irq),
    .code_in      (trap_code),
    .priv         (cur_priv),
    .code_eff     (code_eff),
    .addr_bearing (addr_bearing)
  );

  trap_deleg_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_sel (
    .is_irq   (trap_is_irq),
    .code     (code_eff),
    .priv     (cur_priv),
    .exc_mask (exc_deleg),
    .irq_mask (irq_deleg),
    .to_super (to_super)
  );

  assign tvec_sel = to_super ? s_tvec : m_tvec;

  trap_vec_calc #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .tvec   (tvec_sel),
    .is_irq (trap_is_irq),
    .code   (code_eff),
    .npc    (npc_calc)
  );

  logic [1:0]      priv_q, priv_d, mpp_q, mpp_d;
  logic            sie_q, sie_d, spie_q, spie_d, spp_q, spp_d;
  logic            mie_q, mie_d, mpie_q, mpie_d;
  logic [XLEN-1:0] mcause_q, mcause_d, mepc_q, mepc_d, mtval_q, mtval_d;
  logic [XLEN-1:0] scause_q, scause_d, sepc_q, sepc_d, stval_q, stval_d;
  logic [XLEN-1:0] npc_q;
  logic [XLEN-1:0] cause_val, tval_val;

  // next-state
  always_comb begin
    cause_val = {trap_is_irq, (XLEN-1)'(code_eff)};
    tval_val  = addr_bearing ? trap_addr : '0;
    mcause_d  = mcause_q;
    mepc_d    = mepc_q;
    mtval_d   = mtval_q;
    scause_d  = scause_q;
    sepc_d    = sepc_q;
    stval_d   = stval_q;
    if (to_super) begin
      priv_d   = PRIV_SUPER;
      sie_d    = 1'b0;
      spie_d   = cur_sie;
      spp_d    = cur_priv[0];
      mie_d    = cur_mie;
      mpie_d   = cur_mpie;
      mpp_d    = cur_mpp;
      scause_d = cause_val;
      sepc_d   = trap_pc;
      stval_d  = tval_val;
    end else begin
      priv_d   = PRIV_MACH;
      sie_d    = cur_sie;
      spie_d   = cur_spie;
      spp_d    = cur_spp;
      mie_d    = 1'b0;
      mpie_d   = cur_mie;
      mpp_d    = cur_priv;
      mcause_d = cause_val;
      mepc_d   = trap_pc;
      mtval_d  = tval_val;
    end
  end

  // registers, clock-enabled by trap_valid
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      priv_q   <= PRIV_MACH;
      sie_q    <= 1'b0;
      spie_q   <= 1'b0;
      spp_q    <= 1'b0;
      mie_q    <= 1'b0;
      mpie_q   <= 1'b0;
      mpp_q    <= 2'd0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
      npc_q    <= '0;
    end else if (trap_valid) begin
      priv_q   <= priv_d;
      sie_q    <= sie_d;
      spie_q   <= spie_d;
      spp_q    <= spp_d;
      mie_q    <= mie_d;
      mpie_q   <= mpie_d;
      mpp_q    <= mpp_d;
      mcause_q <= mcause_d;
      mepc_q   <= mepc_d;
      mtval_q  <= mtval_d;
      scause_q <= scause_d;
      sepc_q   <= sepc_d;
      stval_q  <= stval_d;
      npc_q    <= npc_calc;
    end
  end

  assign priv_o   = priv_q;
  assign sie_o    = sie_q;
  assign spie_o   = spie_q;
  assign spp_o    = spp_q;
  assign mie_o    = mie_q;
  assign mpie_o   = mpie_q;
  assign mpp_o    = mpp_q;
  assign mcause_o = mcause_q;
  assign mepc_o   = mepc_q;
  assign mtval_o  = mtval_q;
  assign scause_o = scause_q;
  assign sepc_o   = sepc_q;
  assign stval_o  = stval_q;
  assign npc_o    = npc_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_valid,
  input logic              trap_is_irq,
  input logic [XLEN-1:0]   trap_pc,
  input logic [1:0]        cur_priv,
  input logic              cur_sie,
  input logic              cur_mie,
  input logic [XLEN-1:0]   m_tvec,
  input logic [XLEN-1:0]   s_tvec,
  input logic [1:0]        priv_o,
  input logic              sie_o,
  input logic              spie_o,
  input logic              spp_o,
  input logic              mie_o,
  input logic              mpie_o,
  input logic [1:0]        mpp_o,
  input logic [XLEN-1:0]   mcause_o,
  input logic [XLEN-1:0]   mepc_o,
  input logic [XLEN-1:0]   mtval_o,
  input logic [XLEN-1:0]   scause_o,
  input logic [XLEN-1:0]   sepc_o,
  input logic [XLEN-1:0]   stval_o,
  input logic [XLEN-1:0]   npc_o
);
  AST_MACH_NO_DELEG: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && cur_priv == 2'd3) |=> (priv_o == 2'd3)); // R2

  AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_o == 2'd1) || (priv_o == 2'd3)); // R2

  AST_SUPER_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o != 2'd1 ||
      (!sie_o && spie_o == $past(cur_sie) && spp_o == $past(cur_priv[0])))); // R3

  AST_MACH_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (priv_o != 2'd3 ||
      (!mie_o && mpie_o == $past(cur_mie) && mpp_o == $past(cur_priv)))); // R4

  AST_CAUSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == 2'd3) ? (mcause_o[XLEN-1] == $past(trap_is_irq))
                                     : (scause_o[XLEN-1] == $past(trap_is_irq)))); // R5

  AST_EPC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> ((priv_o == 2'd3) ? (mepc_o == $past(trap_pc))
                                     : (sepc_o == $past(trap_pc)))); // R6

  AST_EXC_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_is_irq) |=>
      (npc_o == ((priv_o == 2'd3) ? {$past(m_tvec[XLEN-1:2]), 2'b00}
                                  : {$past(s_tvec[XLEN-1:2]), 2'b00}))); // R7

  AST_IRQ_TVAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_is_irq) |=>
      ((priv_o == 2'd3) ? (mtval_o == '0) : (stval_o == '0))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> ($stable(priv_o) && $stable(mcause_o) && $stable(scause_o) &&
                     $stable(npc_o) && $stable(mpp_o) && $stable(spp_o))); // R10
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  localparam int XLEN   = 32;
  localparam int CODE_W = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trap_valid, trap_is_irq;
  logic [CODE_W-1:0] trap_code;
  logic [XLEN-1:0]   trap_addr, trap_pc;
  logic [1:0]        cur_priv, cur_mpp;
  logic              cur_sie, cur_spie, cur_spp, cur_mie, cur_mpie;
  logic [XLEN-1:0]   exc_deleg, irq_deleg, m_tvec, s_tvec;
  logic [1:0]        priv_o, mpp_o;
  logic              sie_o, spie_o, spp_o, mie_o, mpie_o;
  logic [XLEN-1:0]   mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o, npc_o;

  trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) dut (.*);

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // expected state
  logic [1:0]      e_priv, e_mpp;
  logic            e_sie, e_spie, e_spp, e_mie, e_mpie;
  logic [XLEN-1:0] e_mcause, e_mepc, e_mtval, e_scause, e_sepc, e_stval, e_npc;

  task automatic chk(input string req, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "priv",   XLEN'(priv_o), XLEN'(e_priv));
    chk(req, "sie",    XLEN'(sie_o),  XLEN'(e_sie));
    chk(req, "spie",   XLEN'(spie_o), XLEN'(e_spie));
    chk(req, "spp",    XLEN'(spp_o),  XLEN'(e_spp));
    chk(req, "mie",    XLEN'(mie_o),  XLEN'(e_mie));
    chk(req, "mpie",   XLEN'(mpie_o), XLEN'(e_mpie));
    chk(req, "mpp",    XLEN'(mpp_o),  XLEN'(e_mpp));
    chk(req, "mcause", mcause_o, e_mcause);
    chk(req, "mepc",   mepc_o,   e_mepc);
    chk(req, "mtval",  mtval_o,  e_mtval);
    chk(req, "scause", scause_o, e_scause);
    chk(req, "sepc",   sepc_o,   e_sepc);
    chk(req, "stval",  stval_o,  e_stval);
    chk(req, "npc",    npc_o,    e_npc);
  endtask

  // arithmetic model of one trap from the requirements
  task automatic model_trap();
    int code;
    logic [XLEN-1:0] mask, tv, tvalv, causev;
    logic sup, addrful;
    code = int'(trap_code);
    if (!trap_is_irq && (code == 8 || code == 9 || code == 11))   // R9
      code = (cur_priv == 2'd0) ? 8 : (cur_priv == 2'd1) ? 9 : 11;
    mask = trap_is_irq ? irq_deleg : exc_deleg;                   // R2
    sup  = (cur_priv <= 2'd1) && (code < XLEN) && mask[code];
    addrful = !trap_is_irq && (code inside {0, 1, 4, 5, 6, 7, 12, 13, 15}); // R8
    tvalv  = addrful ? trap_addr : '0;
    causev = (trap_is_irq ? (32'h1 << (XLEN-1)) : '0) | XLEN'(code); // R5
    tv = sup ? s_tvec : m_tvec;
    e_npc = (tv & ~32'h3) + ((trap_is_irq && tv[1:0] == 2'd1) ? XLEN'(code * 4) : '0); // R7
    if (sup) begin                                                // R3
      e_priv = 2'd1; e_spie = cur_sie; e_spp = cur_priv[0]; e_sie = 1'b0;
      e_mie = cur_mie; e_mpie = cur_mpie; e_mpp = cur_mpp;
      e_scause = causev; e_sepc = trap_pc; e_stval = tvalv;       // R6
    end else begin                                                // R4
      e_priv = 2'd3; e_mpie = cur_mie; e_mpp = cur_priv; e_mie = 1'b0;
      e_sie = cur_sie; e_spie = cur_spie; e_spp = cur_spp;
      e_mcause = causev; e_mepc = trap_pc; e_mtval = tvalv;
    end
  endtask

  // drive at negedge, trap taken at next posedge, check at following negedge;
  // then an idle cycle with scrambled inputs must change nothing (R10)
  task automatic run_trap(input string req);
    model_trap();
    trap_valid = 1'b1;
    @(negedge clk);
    trap_valid = 1'b0;
    chk_all(req);
    trap_pc   = ~trap_pc;
    cur_priv  = 2'd0;
    cur_sie   = ~cur_sie;
    cur_mie   = ~cur_mie;
    trap_code = trap_code ^ 5'h5;
    @(negedge clk);
    chk_all("R10");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; trap_valid = 1'b0; trap_is_irq = 1'b0; trap_code = '0;
    trap_addr = '0; trap_pc = '0; cur_priv = 2'd0; cur_mpp = 2'd0;
    cur_sie = 0; cur_spie = 0; cur_spp = 0; cur_mie = 0; cur_mpie = 0;
    exc_deleg = '0; irq_deleg = '0; m_tvec = '0; s_tvec = '0;
    e_priv = 2'd3; e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0; e_mpie = 0; e_mpp = 0;
    e_mcause = '0; e_mepc = '0; e_mtval = '0; e_scause = '0; e_sepc = '0; e_stval = '0;
    e_npc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_all("R1");

    // ecall rewrite feeding delegation in the same cycle: user raises code 9,
    // only mask bit 8 set -> supervisor, cause 8
    cur_priv = 2'd0; trap_is_irq = 1'b0; trap_code = 5'd9;
    exc_deleg = 32'h0000_0100; irq_deleg = '0;
    m_tvec = 32'h0000_1000; s_tvec = 32'h0000_2001;
    trap_pc = 32'h8000_0040; trap_addr = 32'hDEAD_0000;
    run_trap("R9");
    chk("R9", "ecall to super", XLEN'(priv_o), 32'd1);
    chk("R9", "ecall cause", scause_o, 32'd8);

    // sweep
    for (int p = 0; p < 3; p++) begin
      for (int irq = 0; irq < 2; irq++) begin
        for (int c = 0; c < 16; c++) begin
          for (int dm = 0; dm < 3; dm++) begin
            for (int vm = 0; vm < 3; vm++) begin
              int n;
              n = ((p * 2 + irq) * 16 + c) * 9 + dm * 3 + vm;
              cur_priv    = (p == 2) ? 2'd3 : 2'(p);
              trap_is_irq = irq[0];
              trap_code   = 5'(c);
              trap_addr   = 32'h1000_0000 ^ (n * 32'h111);
              trap_pc     = 32'h8000_0000 + n * 4;
              cur_sie  = n[0]; cur_spie = n[1]; cur_spp = n[2];
              cur_mie  = n[3]; cur_mpie = n[4]; cur_mpp = 2'(n >> 5);
              exc_deleg = (dm == 0) ? 32'h0 : (dm == 1) ? 32'hFFFF_FFFF : 32'h0000_A2B5;
              irq_deleg = (dm == 0) ? 32'h0 : (dm == 1) ? 32'hFFFF_FFFF : 32'h0000_5A4A;
              m_tvec = 32'h0000_4000 + (n << 8) + 32'(vm);
              s_tvec = 32'h0002_0000 + (n << 8) + 32'(vm);
              if (irq == 1) run_trap(vm == 1 ? "R7" : "R5");
              else if (c inside {8, 9, 11}) run_trap("R9");
              else run_trap((dm == 0) ? "R4" : (dm == 1) ? "R3" : "R8");
            end
          end
        end
      end
    end

    // boundary: machine level never delegates even with full masks (R2)
    cur_priv = 2'd3; trap_is_irq = 1'b1; trap_code = 5'd5;
    exc_deleg = 32'hFFFF_FFFF; irq_deleg = 32'hFFFF_FFFF;
    m_tvec = 32'h0000_0101; trap_pc = 32'h8000_1000;
    run_trap("R2");
    chk("R2", "machine stays machine", XLEN'(priv_o), 32'd3);
    chk("R7", "vectored irq 5", npc_o, 32'h0000_0114);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule